// File: doc/BRIEF.md
# Addressing-Mode Effective Address Generator

This unit turns one operand request into the operand that an 8-bit processor core needs. A request carries an addressing mode code, up to two operand bytes and snapshots of the X and Y index registers. The result is one of three things: a 16-bit effective address, an immediate data byte, or a signed branch displacement. Indexing uses wrap-around where it applies. Modes that go through a pointer read the two pointer bytes over a synchronous byte-read port. The unit then reports completion with a one-cycle done strobe and a tag that names the kind of result.

Separately, the unit returns the operand byte count of whatever mode code is on its request input, with no clock involved. The instruction fetch stage uses this count to step past the operand bytes. Opcode decoding and instruction execution live elsewhere. A new request is taken only while the unit is not busy with a pointer fetch.

Top module: `ea_addr_gen`

## Requirements
- R1: `op_bytes` gives, combinationally, the operand length of `req_mode`. Mode codes and lengths: 0 accumulator (0), 1 implied (0), 2 immediate (1), 3 zero page (1), 4 zero page+X (1), 5 zero page+Y (1), 6 relative (1), 7 absolute (2), 8 absolute+X (2), 9 absolute+Y (2), 10 indirect (2), 11 pre-indexed indirect (1), 12 post-indexed indirect (1). Codes 13 to 15 give 0.
- R2: Immediate mode (code 2) raises `done` in the cycle after acceptance. It sets `res_kind` = 2 (data) and `res_value` = `req_lo`, and it makes no memory read.
- R3: Relative mode (code 6) raises `done` in the cycle after acceptance. It sets `res_kind` = 3 (offset) and `res_value` = `req_lo`, to be read as a two's-complement displacement.
- R4: Zero-page modes finish in the cycle after acceptance with `res_kind` = 1 (address). The address is {0x00, lo} for code 3, and {0x00, (lo+X) mod 256} or {0x00, (lo+Y) mod 256} for codes 4 and 5, so the high byte is always zero and `req_hi` is ignored.
- R5: Absolute modes finish in the cycle after acceptance with `res_kind` = 1. The address is {hi, lo} for code 7, and that value plus the zero-extended X or Y, modulo 65536, for codes 8 and 9.
- R6: Indirect mode (code 10) reads the byte at P = {hi, lo} and then the byte at (P+1) mod 65536, one read per cycle, with read data arriving one cycle after its address. The result is the little-endian pair: the first byte is the low half. `done` is raised four cycles after acceptance.
- R7: Pre-indexed indirect (code 11) reads its pointer from Z = (lo+X) mod 256 and (Z+1) mod 256, both in page zero, and returns that pointer as the address.
- R8: Post-indexed indirect (code 12) reads its pointer from lo and (lo+1) mod 256 in page zero, then returns pointer + Y modulo 65536.
- R9: Accumulator and implied modes (codes 0 and 1), and codes 13 to 15, finish in the cycle after acceptance with `res_kind` = 0 (none) and make no memory read.
- R10: `done` lasts one cycle per accepted request. While `busy` is high, `req_valid` is ignored: it neither alters the running fetch nor produces a second result.
- R11: During and directly after reset, `done`, `busy` and `mem_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_mode | input | 4 | Addressing mode code |
| req_lo | input | 8 | First operand byte |
| req_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| op_bytes | output | 2 | Operand byte count of `req_mode` |
| busy | output | 1 | Pointer fetch in progress |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| done | output | 1 | Result strobe |
| res_kind | output | 2 | 0 none, 1 address, 2 data, 3 offset |
| res_addr | output | 16 | Effective address |
| res_value | output | 8 | Immediate data or displacement |

## Verification
The bench builds the unit with the default byte width of 8, which gives a 16-bit address. With this width the wrap corners can be reached with ordinary operand values. A zero-page base of 0xF0 or 0xFF, plus an index, crosses the end of page zero. An absolute base of 0x12FF or 0xFFFF crosses a page boundary or the top of the address space. Pointers placed at 0x00FF check that the second pointer byte is read from 0x0000 in the indexed-indirect modes. The same kind of pointer placed at 0x12FF checks that the second read goes to 0x1300 in plain indirect mode.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [3:0] {
        AM_ACC   = 4'd0,
        AM_IMPL  = 4'd1,
        AM_IMM   = 4'd2,
        AM_ZP    = 4'd3,
        AM_ZPX   = 4'd4,
        AM_ZPY   = 4'd5,
        AM_REL   = 4'd6,
        AM_ABS   = 4'd7,
        AM_ABSX  = 4'd8,
        AM_ABSY  = 4'd9,
        AM_IND   = 4'd10,
        AM_PREX  = 4'd11,
        AM_POSTY = 4'd12
    } am_e;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_ADDR = 2'd1,
        RK_DATA = 2'd2,
        RK_OFS  = 2'd3
    } rk_e;

    // Operand byte count per mode (R1); unknown codes take none.
    function automatic logic [1:0] operand_len(logic [3:0] m);
        case (m)
            AM_IMM, AM_ZP, AM_ZPX, AM_ZPY, AM_REL,
            AM_PREX, AM_POSTY:                      return 2'd1;
            AM_ABS, AM_ABSX, AM_ABSY, AM_IND:       return 2'd2;
            default:                                return 2'd0;
        endcase
    endfunction

    function automatic logic needs_pointer(logic [3:0] m);
        return (m == AM_IND) || (m == AM_PREX) || (m == AM_POSTY);
    endfunction

endpackage

// File: rtl/ea_direct.sv
// Single-cycle result for every mode that needs no memory access.
module ea_direct
    import ea_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic [3:0]        mode,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        kind,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] zp_x, zp_y;
    logic [ADDR_W-1:0] base;

    assign zp_x = lo + x;
    assign zp_y = lo + y;
    assign base = {hi, lo};

    always_comb begin
        addr  = '0;
        kind  = RK_NONE;
        value = lo;
        case (mode)
            AM_IMM:  kind = RK_DATA;
            AM_REL:  kind = RK_OFS;
            AM_ZP:   begin kind = RK_ADDR; addr = {{DATA_W{1'b0}}, lo};   end
            AM_ZPX:  begin kind = RK_ADDR; addr = {{DATA_W{1'b0}}, zp_x}; end
            AM_ZPY:  begin kind = RK_ADDR; addr = {{DATA_W{1'b0}}, zp_y}; end
            AM_ABS:  begin kind = RK_ADDR; addr = base; end
            AM_ABSX: begin kind = RK_ADDR; addr = base + {{DATA_W{1'b0}}, x}; end
            AM_ABSY: begin kind = RK_ADDR; addr = base + {{DATA_W{1'b0}}, y}; end
            default: kind = RK_NONE;
        endcase
    end
endmodule

// File: rtl/ea_ptr_fetch.sv
// Two-read pointer fetch for the indirect modes.
module ea_ptr_fetch
    import ea_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fin,
    output logic [ADDR_W-1:0] target
);
    typedef enum logic [1:0] {F_IDLE, F_LO, F_HI, F_FIN} fst_e;

    fst_e              st;
    logic [ADDR_W-1:0] ptr0, ptr1, post_add;
    logic [DATA_W-1:0] lo_byte;

    // Pointer locations chosen at start
    logic [ADDR_W-1:0] n_ptr0, n_ptr1, n_add;
    logic [DATA_W-1:0] zx;

    assign zx = lo + x;

    always_comb begin
        n_add = '0;
        case (mode)
            AM_PREX: begin
                n_ptr0 = {{DATA_W{1'b0}}, zx};
                n_ptr1 = {{DATA_W{1'b0}}, zx + 1'b1};
            end
            AM_POSTY: begin
                n_ptr0 = {{DATA_W{1'b0}}, lo};
                n_ptr1 = {{DATA_W{1'b0}}, lo + 1'b1};
                n_add  = {{DATA_W{1'b0}}, y};
            end
            default: begin
                n_ptr0 = {hi, lo};
                n_ptr1 = {hi, lo} + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= F_IDLE;
            ptr0     <= '0;
            ptr1     <= '0;
            post_add <= '0;
            lo_byte  <= '0;
        end else begin
            case (st)
                F_IDLE: if (start) begin
                    st       <= F_LO;
                    ptr0     <= n_ptr0;
                    ptr1     <= n_ptr1;
                    post_add <= n_add;
                end
                F_LO:   st <= F_HI;
                F_HI:   begin st <= F_FIN; lo_byte <= mem_rdata; end
                default: st <= F_IDLE;
            endcase
        end
    end

    assign busy     = (st != F_IDLE);
    assign mem_rd   = (st == F_LO) || (st == F_HI);
    assign mem_addr = (st == F_LO) ? ptr0 : ptr1;
    assign fin      = (st == F_FIN);
    assign target   = {mem_rdata, lo_byte} + post_add;
endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
    import ea_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [3:0]        req_mode,
    input  logic [DATA_W-1:0] req_lo,
    input  logic [DATA_W-1:0] req_hi,
    input  logic [DATA_W-1:0] idx_x,
    input  logic [DATA_W-1:0] idx_y,
    output logic [1:0]        op_bytes,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [1:0]        res_kind,
    output logic [ADDR_W-1:0] res_addr,
    output logic [DATA_W-1:0] res_value
);
    logic              accept, go_ptr, fin;
    logic [ADDR_W-1:0] d_addr, f_target;
    logic [1:0]        d_kind;
    logic [DATA_W-1:0] d_value;

    assign op_bytes = operand_len(req_mode);
    assign accept   = req_valid && !busy;
    assign go_ptr   = accept && needs_pointer(req_mode);

    ea_direct #(.DATA_W(DATA_W)) u_direct (
        .mode(req_mode), .lo(req_lo), .hi(req_hi), .x(idx_x), .y(idx_y),
        .addr(d_addr), .kind(d_kind), .value(d_value)
    );

    ea_ptr_fetch #(.DATA_W(DATA_W)) u_fetch (
        .clk(clk), .rst(rst), .start(go_ptr), .mode(req_mode),
        .lo(req_lo), .hi(req_hi), .x(idx_x), .y(idx_y),
        .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .fin(fin), .target(f_target)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            res_kind  <= RK_NONE;
            res_addr  <= '0;
            res_value <= '0;
        end else begin
            done <= 1'b0;
            if (accept && !go_ptr) begin
                done      <= 1'b1;
                res_kind  <= d_kind;
                res_addr  <= d_addr;
                res_value <= d_value;
            end else if (fin) begin
                done     <= 1'b1;
                res_kind <= RK_ADDR;
                res_addr <= f_target;
            end
        end
    end
endmodule

// File: rtl/ea_checker.sv
module ea_checker
    import ea_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [3:0]        req_mode,
    input logic              busy,
    input logic              done,
    input logic [1:0]        res_kind,
    input logic [ADDR_W-1:0] res_addr,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr
);
    logic take;
    assign take = req_valid && !busy;

    assert_reset_quiet_R11: assert property (@(posedge clk)
        rst |=> (!done && !busy && !mem_rd));

    assert_no_done_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    assert_read_only_busy_R6: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> busy);

    assert_second_read_next_byte_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_rd)) |-> (mem_addr[DATA_W-1:0] == $past(mem_addr[DATA_W-1:0]) + 1'b1));

    assert_imm_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        (take && req_mode == AM_IMM) |=> (done && res_kind == RK_DATA && !mem_rd));

    assert_rel_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (take && req_mode == AM_REL) |=> (done && res_kind == RK_OFS));

    assert_zp_page_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (take && (req_mode == AM_ZPX || req_mode == AM_ZPY)) |=>
            (done && res_addr[ADDR_W-1:DATA_W] == '0));

    assert_none_kind_R9: assert property (@(posedge clk) disable iff (rst)
        (take && (req_mode == AM_ACC || req_mode == AM_IMPL)) |=> (done && res_kind == RK_NONE));
endmodule

bind ea_addr_gen ea_checker #(.DATA_W(DATA_W)) u_ea_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .busy(busy), .done(done), .res_kind(res_kind), .res_addr(res_addr),
    .mem_rd(mem_rd), .mem_addr(mem_addr)
);

// File: tb/tb_ea_addr_gen.sv
`timescale 1ns/1ps
module tb_ea_addr_gen;
    import ea_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_mode = '0;
    logic [7:0]  req_lo = '0, req_hi = '0, idx_x = '0, idx_y = '0;
    logic [1:0]  op_bytes;
    logic        busy, mem_rd, done;
    logic [15:0] mem_addr, res_addr;
    logic [7:0]  mem_rdata = '0, res_value;
    logic [1:0]  res_kind;

    int n_chk = 0, n_bad = 0;
    int lat;
    int rd_n;
    logic [15:0] rd_a [0:7];

    always #5 clk = ~clk;

    ea_addr_gen dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_lo(req_lo), .req_hi(req_hi), .idx_x(idx_x), .idx_y(idx_y),
        .op_bytes(op_bytes), .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .done(done), .res_kind(res_kind),
        .res_addr(res_addr), .res_value(res_value)
    );

    // Byte memory contents as a function of address
    function automatic logic [7:0] memf(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

    always @(negedge clk) if (mem_rd && rd_n < 8) begin
        rd_a[rd_n] = mem_addr;
        rd_n = rd_n + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] m, input logic [7:0] lo, hi, x, y);
        @(negedge clk);
        rd_n = 0;
        req_valid = 1'b1; req_mode = m; req_lo = lo; req_hi = hi; idx_x = x; idx_y = y;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_pulse(input string req);
        @(negedge clk);
        chk(req, {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R11 done", {31'd0, done}, 0);
        chk("R11 busy", {31'd0, busy}, 0);
        chk("R11 mem_rd", {31'd0, mem_rd}, 0);
    endtask

    task automatic t_lengths;
        for (int m = 0; m < 16; m++) begin
            logic [1:0] e;
            case (m)
                2, 3, 4, 5, 6, 11, 12: e = 2'd1;
                7, 8, 9, 10:           e = 2'd2;
                default:               e = 2'd0;
            endcase
            req_mode = 4'(m);
            #1;
            chk($sformatf("R1 mode %0d", m), {30'd0, op_bytes}, {30'd0, e});
        end
    endtask

    task automatic t_imm_rel;
        run(AM_IMM, 8'h3C, 8'h00, 8'h11, 8'h22);
        chk("R2 latency", lat, 1);
        chk("R2 kind", res_kind, 2);
        chk("R2 value", res_value, 8'h3C);
        chk("R2 no read", rd_n, 0);
        run(AM_REL, 8'hFA, 8'h00, 8'h00, 8'h00);
        chk("R3 latency", lat, 1);
        chk("R3 kind", res_kind, 3);
        chk("R3 value", res_value, 8'hFA);
    endtask

    task automatic t_none;
        run(AM_ACC, 8'h12, 8'h34, 8'h00, 8'h00);
        chk("R9 acc kind", res_kind, 0);
        chk("R9 acc latency", lat, 1);
        run(AM_IMPL, 8'h00, 8'h00, 8'h00, 8'h00);
        chk("R9 impl kind", res_kind, 0);
        run(4'd14, 8'h00, 8'h00, 8'h00, 8'h00);
        chk("R9 unused code kind", res_kind, 0);
        chk("R9 no read", rd_n, 0);
    endtask

    task automatic t_zp;
        run(AM_ZP, 8'h44, 8'h99, 8'h00, 8'h00);
        chk("R4 zp", res_addr, 16'h0044);
        chk("R4 zp kind", res_kind, 1);
        run(AM_ZPX, 8'hF0, 8'h99, 8'h20, 8'h00);
        chk("R4 zpx wrap", res_addr, 16'h0010);
        run(AM_ZPY, 8'h80, 8'h00, 8'h00, 8'h7F);
        chk("R4 zpy", res_addr, 16'h00FF);
        chk("R4 latency", lat, 1);
    endtask

    task automatic t_abs;
        run(AM_ABS, 8'hEF, 8'hBE, 8'h05, 8'h06);
        chk("R5 abs", res_addr, 16'hBEEF);
        run(AM_ABSX, 8'hFF, 8'h12, 8'h01, 8'h00);
        chk("R5 absx carry", res_addr, 16'h1300);
        run(AM_ABSY, 8'hFF, 8'hFF, 8'h00, 8'h02);
        chk("R5 absy top wrap", res_addr, 16'h0001);
        chk("R5 kind", res_kind, 1);
    endtask

    task automatic t_ind;
        run(AM_IND, 8'hFF, 8'h12, 8'h00, 8'h00);
        chk("R6 latency", lat, 4);
        chk("R6 reads", rd_n, 2);
        chk("R6 first addr", rd_a[0], 16'h12FF);
        chk("R6 second addr", rd_a[1], 16'h1300);
        chk("R6 target", res_addr, {memf(16'h1300), memf(16'h12FF)});
        chk("R6 kind", res_kind, 1);
        check_pulse("R10 pulse after indirect");
    endtask

    task automatic t_prex;
        run(AM_PREX, 8'hFE, 8'h77, 8'h01, 8'h09);
        chk("R7 first addr", rd_a[0], 16'h00FF);
        chk("R7 second addr wrap", rd_a[1], 16'h0000);
        chk("R7 target", res_addr, {memf(16'h0000), memf(16'h00FF)});
        run(AM_PREX, 8'h10, 8'h00, 8'h05, 8'h00);
        chk("R7 plain", res_addr, {memf(16'h0016), memf(16'h0015)});
    endtask

    task automatic t_posty;
        logic [15:0] p;
        run(AM_POSTY, 8'hFF, 8'h55, 8'h03, 8'hF0);
        p = {memf(16'h0000), memf(16'h00FF)};
        chk("R8 first addr", rd_a[0], 16'h00FF);
        chk("R8 second addr wrap", rd_a[1], 16'h0000);
        chk("R8 target", res_addr, p + 16'h00F0);
        chk("R8 latency", lat, 4);
    endtask

    task automatic t_busy_ignore;
        int dn;
        @(negedge clk);
        rd_n = 0;
        req_valid = 1'b1; req_mode = AM_IND; req_lo = 8'h00; req_hi = 8'h40;
        @(negedge clk);
        req_mode = AM_IMM; req_lo = 8'h99;      // held while busy
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        dn = 0;
        for (int i = 0; i < 6; i++) begin
            if (done) begin
                dn++;
                chk("R10 kept indirect kind", res_kind, 1);
                chk("R10 kept target", res_addr, {memf(16'h4001), memf(16'h4000)});
            end
            @(negedge clk);
        end
        chk("R10 single result", dn, 1);
        chk("R10 two reads only", rd_n, 2);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rd_n = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lengths();
        t_imm_rel();
        t_none();
        t_zp();
        t_abs();
        t_ind();
        t_prex();
        t_posty();
        t_busy_ignore();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule